// File: doc/BRIEF.md
# Lamp start and restart sequencer

This block sequences the starting of a gas-discharge lamp ballast. A saturating digital ramp stands in for a timing capacitor. The ramp climbs at one rate and falls at a much slower one, and the levels it crosses move the block through its operating modes:

- filament heating at a fixed high inverter frequency;
- a strike phase at minimum frequency, with dimming feedback locked out;
- normal running, in which the oscillator follows the dimming command.

A lamp-out interrupt shuts the inverter off. The block then waits while the ramp decays to a low level, and restarts with a fresh heating phase. That phase begins from the low level, so it is shorter than the first one after power-up.

The mode, the inverter enable and two selects for the oscillator are decoded from the mode register. One select calls for the preheat frequency; the other tells the oscillator to obey the dimming loop. Ramp levels are expressed in millivolts on a 7.5 V full scale and turned into codes by parameter arithmetic. The step intervals for charging and discharging are parameters in clock cycles.

Top module: `lamp_start_seq`

## Requirements
- R1: While `rst_n` is low or `pwr_good` is low, `mode` is 0 (off) and `inv_en`, `dim_sel`, `heat_sel` are 0. A `pwr_good` high sampled in off gives mode 1 (heat) in the next cycle, with the ramp at the initial code.
- R2: A level of `mv` millivolts maps to the code floor(mv*(2^RAMP_W-1)/7500). The defaults are: initial 700 mV, heat end 4800 mV, lockout end 6800 mV, restart 1200 mV. The ramp saturates at 2^RAMP_W-1.
- R3: The first heat phase after power-up lasts (HEAT_CODE-INIT_CODE)*CHG_DIV+1 cycles, with `inv_en`=1, `heat_sel`=1, `dim_sel`=0.
- R4: The lockout phase (mode 2) lasts (LOCK_CODE-HEAT_CODE)*CHG_DIV cycles, with `inv_en`=1 and both selects 0.
- R5: Run mode (mode 3) drives `inv_en`=1 and `dim_sel`=1. The ramp keeps charging to its ceiling and holds there, and the block stays in run.
- R6: `lamp_out` high in heat, lockout or run gives mode 4 (inhibit) in the next cycle, with all three outputs 0.
- R7: Inhibit lasts (R-RESTART_CODE)*DIS_DIV+1 cycles, where R is the ramp code on entry. `lamp_out` has no effect during inhibit.
- R8: Leaving inhibit enters heat with the ramp at the restart code, even if the ramp was below it. A restart heat phase lasts (HEAT_CODE-RESTART_CODE)*CHG_DIV+1 cycles, which is shorter than the first.
- R9: Mode codes are off 0, heat 1, lockout 2, run 3, inhibit 4. Only these transitions occur: off to heat, heat to lockout, lockout to run, heat, lockout or run to inhibit, inhibit to heat, and any mode to off.
- R10: Loss of `pwr_good` in any mode gives off in the next cycle. The next power-up repeats the full first heat length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above start threshold, synchronous |
| lamp_out | input | 1 | Lamp-out interrupt flag, synchronous |
| mode | output | 3 | Current mode code (R9) |
| inv_en | output | 1 | Inverter enable |
| dim_sel | output | 1 | Oscillator follows dimming feedback |
| heat_sel | output | 1 | Oscillator runs at preheat frequency |

## Verification
The assertions take `pwr_good` and `lamp_out` to be synchronous to `clk`. They also rely on the thresholds being ordered initial < restart < heat end < lockout end < ceiling, which the default parameters give. The bench drives both inputs only on the falling edge and keeps the default thresholds. It overrides only the step intervals, to short values that still keep discharge slower than charge. The random phase mixes interrupt pulses, held interrupts and short power dropouts at random moments. A monitor checks every cycle for illegal mode transitions.

// File: rtl/lss_pkg.sv
package lss_pkg;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_HEAT = 3'd1,
    MODE_LOCK = 3'd2,
    MODE_RUN  = 3'd3,
    MODE_HOLD = 3'd4
  } lss_mode_e;

  localparam int unsigned FULL_SCALE_MV = 7500;

  // Level in millivolts to ramp code on a full scale of FULL_SCALE_MV.
  function automatic int unsigned mv_to_code(input int unsigned mv, input int unsigned width);
    longint unsigned span;
    longint unsigned prod;
    span = (64'd1 << width) - 64'd1;
    prod = longint'(mv) * span;
    return int'(prod / longint'(FULL_SCALE_MV));
  endfunction

  function automatic int unsigned ramp_ceiling(input int unsigned width);
    return int'((64'd1 << width) - 64'd1);
  endfunction

  function automatic logic is_driving(input lss_mode_e m);
    return (m == MODE_HEAT) || (m == MODE_LOCK) || (m == MODE_RUN);
  endfunction

endpackage

// File: rtl/lss_rate_tick.sv
module lss_rate_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = run;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/lss_ramp.sv
module lss_ramp #(
  parameter int unsigned RAMP_W  = 12,
  parameter int unsigned INIT    = 0,
  parameter int unsigned FLOOR   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_init,
  input  logic              load_floor,
  input  logic              up,
  input  logic              down,
  output logic [RAMP_W-1:0] level
);
  localparam logic [RAMP_W-1:0] INIT_C  = RAMP_W'(INIT);
  localparam logic [RAMP_W-1:0] FLOOR_C = RAMP_W'(FLOOR);
  localparam logic [RAMP_W-1:0] CEIL_C  = '1;

  logic at_ceiling;
  logic above_floor;
  assign at_ceiling  = (level == CEIL_C);
  assign above_floor = (level > FLOOR_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    level <= INIT_C;
    else if (load_init)            level <= INIT_C;
    else if (load_floor)           level <= FLOOR_C;
    else if (up && !at_ceiling)    level <= level + 1'b1;
    else if (down && above_floor)  level <= level - 1'b1;
  end
endmodule

// File: rtl/lss_mode_fsm.sv
module lss_mode_fsm import lss_pkg::*; #(
  parameter int unsigned RAMP_W       = 12,
  parameter int unsigned HEAT_CODE    = 2620,
  parameter int unsigned LOCK_CODE    = 3712,
  parameter int unsigned RESTART_CODE = 655
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              lamp_out,
  input  logic [RAMP_W-1:0] level,
  output lss_mode_e         state,
  output logic              chg_run,
  output logic              dis_run,
  output logic              ramp_init,
  output logic              ramp_restart
);
  localparam logic [RAMP_W-1:0] HEAT_C    = RAMP_W'(HEAT_CODE);
  localparam logic [RAMP_W-1:0] LOCK_C    = RAMP_W'(LOCK_CODE);
  localparam logic [RAMP_W-1:0] RESTART_C = RAMP_W'(RESTART_CODE);

  lss_mode_e nxt;

  always_comb begin
    nxt = state;
    if (!pwr_good) begin
      nxt = MODE_OFF;
    end else begin
      case (state)
        MODE_OFF:  nxt = MODE_HEAT;
        MODE_HEAT: if (lamp_out)            nxt = MODE_HOLD;
                   else if (level >= HEAT_C) nxt = MODE_LOCK;
        MODE_LOCK: if (lamp_out)            nxt = MODE_HOLD;
                   else if (level >= LOCK_C) nxt = MODE_RUN;
        MODE_RUN:  if (lamp_out)            nxt = MODE_HOLD;
        MODE_HOLD: if (level <= RESTART_C)  nxt = MODE_HEAT;
        default:   nxt = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= MODE_OFF;
    else        state <= nxt;
  end

  assign chg_run      = is_driving(state);
  assign dis_run      = (state == MODE_HOLD);
  assign ramp_init    = !pwr_good || (state == MODE_OFF);
  assign ramp_restart = (state == MODE_HOLD) && (nxt == MODE_HEAT);
endmodule

// File: rtl/lamp_start_seq.sv
module lamp_start_seq import lss_pkg::*; #(
  parameter int unsigned RAMP_W      = 12,
  parameter int unsigned CHG_DIV     = 1024,
  parameter int unsigned DIS_DIV     = 16384,
  parameter int unsigned INIT_MV     = 700,
  parameter int unsigned HEAT_END_MV = 4800,
  parameter int unsigned LOCK_END_MV = 6800,
  parameter int unsigned RESTART_MV  = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       lamp_out,
  output logic [2:0] mode,
  output logic       inv_en,
  output logic       dim_sel,
  output logic       heat_sel
);
  localparam int unsigned INIT_CODE    = mv_to_code(INIT_MV, RAMP_W);
  localparam int unsigned HEAT_CODE    = mv_to_code(HEAT_END_MV, RAMP_W);
  localparam int unsigned LOCK_CODE    = mv_to_code(LOCK_END_MV, RAMP_W);
  localparam int unsigned RESTART_CODE = mv_to_code(RESTART_MV, RAMP_W);

  lss_mode_e         state;
  logic [RAMP_W-1:0] ramp_lvl;
  logic              chg_run;
  logic              dis_run;
  logic              chg_tick;
  logic              dis_tick;
  logic              ramp_init;
  logic              ramp_restart;

  lss_mode_fsm #(
    .RAMP_W(RAMP_W), .HEAT_CODE(HEAT_CODE),
    .LOCK_CODE(LOCK_CODE), .RESTART_CODE(RESTART_CODE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lamp_out(lamp_out),
    .level(ramp_lvl), .state(state), .chg_run(chg_run), .dis_run(dis_run),
    .ramp_init(ramp_init), .ramp_restart(ramp_restart)
  );

  lss_rate_tick #(.DIV(CHG_DIV)) u_chg_rate (
    .clk(clk), .rst_n(rst_n), .run(chg_run), .tick(chg_tick)
  );

  lss_rate_tick #(.DIV(DIS_DIV)) u_dis_rate (
    .clk(clk), .rst_n(rst_n), .run(dis_run), .tick(dis_tick)
  );

  lss_ramp #(
    .RAMP_W(RAMP_W), .INIT(INIT_CODE), .FLOOR(RESTART_CODE)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .load_init(ramp_init), .load_floor(ramp_restart),
    .up(chg_tick), .down(dis_tick), .level(ramp_lvl)
  );

  assign mode     = state;
  assign inv_en   = is_driving(state);
  assign dim_sel  = (state == MODE_RUN);
  assign heat_sel = (state == MODE_HEAT);
endmodule

// File: rtl/lss_chk.sv
module lss_chk import lss_pkg::*; #(
  parameter int unsigned RAMP_W      = 12,
  parameter int unsigned INIT_MV     = 700,
  parameter int unsigned HEAT_END_MV = 4800,
  parameter int unsigned LOCK_END_MV = 6800,
  parameter int unsigned RESTART_MV  = 1200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              lamp_out,
  input logic [2:0]        mode,
  input logic              inv_en,
  input logic [RAMP_W-1:0] ramp,
  input logic              chg_tick
);
  localparam logic [RAMP_W-1:0] HEAT_C    = RAMP_W'(mv_to_code(HEAT_END_MV, RAMP_W));
  localparam logic [RAMP_W-1:0] LOCK_C    = RAMP_W'(mv_to_code(LOCK_END_MV, RAMP_W));
  localparam logic [RAMP_W-1:0] RESTART_C = RAMP_W'(mv_to_code(RESTART_MV, RAMP_W));

  p_off_unpowered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> mode == MODE_OFF);

  p_heat_ramp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HEAT && pwr_good && !chg_tick) |=> $stable(ramp));

  p_lock_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_LOCK |-> (ramp >= HEAT_C && ramp <= LOCK_C));

  p_run_above_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_RUN |-> ramp >= LOCK_C);

  p_lampout_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && lamp_out &&
     (mode == MODE_HEAT || mode == MODE_LOCK || mode == MODE_RUN)) |=> mode == MODE_HOLD);

  p_hold_outputs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_HOLD |-> !inv_en);

  p_hold_no_charge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_HOLD |-> !chg_tick);

  p_restart_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HEAT && $past(mode) == MODE_HOLD) |-> ramp == RESTART_C);

  // INIT_MV is kept for a uniform bind interface; initial level seen via R1 path.
  p_init_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HEAT && $past(mode) == MODE_OFF) |->
      ramp == RAMP_W'(mv_to_code(INIT_MV, RAMP_W)));
endmodule

bind lamp_start_seq lss_chk #(
  .RAMP_W(RAMP_W), .INIT_MV(INIT_MV), .HEAT_END_MV(HEAT_END_MV),
  .LOCK_END_MV(LOCK_END_MV), .RESTART_MV(RESTART_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lamp_out(lamp_out),
  .mode(mode), .inv_en(inv_en), .ramp(ramp_lvl), .chg_tick(chg_tick)
);

// File: tb/lamp_start_seq_tb.sv
module lamp_start_seq_tb;
  localparam int W   = 12;
  localparam int CHG = 2;
  localparam int DIS = 8;

  // R2: bench's own level arithmetic
  function automatic int code_of(input int mv);
    return (mv * ((1 << W) - 1)) / 7500;
  endfunction

  localparam int C_INIT = (700  * 4095) / 7500;
  localparam int C_HEAT = (4800 * 4095) / 7500;
  localparam int C_LOCK = (6800 * 4095) / 7500;
  localparam int C_RST  = (1200 * 4095) / 7500;
  localparam int C_CEIL = 4095;

  logic clk = 1'b0;
  logic rst_n, pwr_good, lamp_out;
  logic [2:0] mode;
  logic inv_en, dim_sel, heat_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit monitor_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lamp_start_seq #(.RAMP_W(W), .CHG_DIV(CHG), .DIS_DIV(DIS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lamp_out(lamp_out),
    .mode(mode), .inv_en(inv_en), .dim_sel(dim_sel), .heat_sel(heat_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // R9: expected output decode per mode
  function automatic logic [2:0] exp_outs(input logic [2:0] m);
    case (m)
      3'd1: return 3'b101;  // inv, dim, heat
      3'd2: return 3'b100;
      3'd3: return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  function automatic bit legal_step(input logic [2:0] p, input logic [2:0] c, input bit pg, input bit lo);
    if (!pg) return c == 3'd0;
    case (p)
      3'd0: return c == 3'd1;
      3'd1: return lo ? (c == 3'd4) : (c == 3'd1 || c == 3'd2);
      3'd2: return lo ? (c == 3'd4) : (c == 3'd2 || c == 3'd3);
      3'd3: return lo ? (c == 3'd4) : (c == 3'd3);
      3'd4: return c == 3'd4 || c == 3'd1;
      default: return 1'b0;
    endcase
  endfunction

  logic pg_e, lo_e, rst_e;
  logic [2:0] prev_mode;
  always @(posedge clk) begin
    pg_e  <= pwr_good;
    lo_e  <= lamp_out;
    rst_e <= rst_n;
  end

  always @(negedge clk) begin
    if (monitor_on && rst_e) begin
      chk(legal_step(prev_mode, mode, pg_e, lo_e), "R9 transition", int'(mode), int'(prev_mode));
      chk({inv_en, dim_sel, heat_sel} == exp_outs(mode), "R9 decode",
          int'({inv_en, dim_sel, heat_sel}), int'(exp_outs(mode)));
    end
    prev_mode = mode;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic count_mode(input logic [2:0] m, input bit noise, output int n);
    n = 0;
    while (mode == m && n < 60000) begin
      n++;
      if (noise) lamp_out = 1'($urandom);
      step();
    end
    lamp_out = 1'b0;
  endtask

  initial begin
    int n, first_len, restart_len;
    void'($urandom(32'd5150));
    rst_n = 1'b0; pwr_good = 1'b0; lamp_out = 1'b0;
    repeat (4) step();
    chk(mode == 3'd0 && !inv_en && !dim_sel && !heat_sel, "R1 reset", int'(mode), 0);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    repeat (5) step();
    chk(mode == 3'd0 && !inv_en, "R1 unpowered", int'(mode), 0);

    chk(code_of(700) == C_INIT && C_INIT < C_RST && C_RST < C_HEAT && C_HEAT < C_LOCK
        && C_LOCK < C_CEIL, "R2 ordering", C_HEAT, code_of(4800));

    first_len   = (C_HEAT - C_INIT) * CHG + 1;
    restart_len = (C_HEAT - C_RST) * CHG + 1;

    pwr_good = 1'b1;
    step();
    chk(mode == 3'd1 && heat_sel && inv_en, "R1 power-up to heat", int'(mode), 1);
    count_mode(3'd1, 1'b0, n);
    chk(n == first_len, "R3 first heat length (R2 codes)", n, first_len);
    chk(mode == 3'd2, "R4 lockout follows heat", int'(mode), 2);
    count_mode(3'd2, 1'b0, n);
    chk(n == (C_LOCK - C_HEAT) * CHG, "R4 lockout length", n, (C_LOCK - C_HEAT) * CHG);
    chk(mode == 3'd3 && dim_sel && inv_en, "R5 run outputs", int'(mode), 3);
    repeat ((C_CEIL - C_LOCK) * CHG + 8) step();
    chk(mode == 3'd3, "R5 run holds at ceiling", int'(mode), 3);

    lamp_out = 1'b1; step(); lamp_out = 1'b0;
    chk(mode == 3'd4 && !inv_en && !dim_sel && !heat_sel, "R6 inhibit from run", int'(mode), 4);
    count_mode(3'd4, 1'b1, n);
    chk(n == (C_CEIL - C_RST) * DIS + 1, "R7 inhibit length from ceiling", n, (C_CEIL - C_RST) * DIS + 1);
    chk(mode == 3'd1, "R8 restart into heat", int'(mode), 1);
    count_mode(3'd1, 1'b0, n);
    chk(n == restart_len, "R8 restart heat length", n, restart_len);
    chk(n < first_len, "R8 restart shorter", n, first_len);

    count_mode(3'd2, 1'b0, n);
    chk(mode == 3'd3, "R5 run again", int'(mode), 3);
    pwr_good = 1'b0; step();
    chk(mode == 3'd0 && !inv_en && !dim_sel, "R10 power loss in run", int'(mode), 0);
    pwr_good = 1'b1; step();
    chk(mode == 3'd1, "R10 repower heat", int'(mode), 1);
    count_mode(3'd1, 1'b0, n);
    chk(n == first_len, "R10 full first heat again", n, first_len);

    repeat (50) step();
    lamp_out = 1'b1; step(); lamp_out = 1'b0;
    chk(mode == 3'd4, "R6 inhibit from lockout", int'(mode), 4);
    count_mode(3'd4, 1'b0, n);
    count_mode(3'd1, 1'b0, n);
    chk(n == restart_len, "R8 heat after lockout interrupt", n, restart_len);

    pwr_good = 1'b0; step(); pwr_good = 1'b1; step();
    count_mode(3'd1, 1'b0, n);
    count_mode(3'd2, 1'b0, n);
    lamp_out = 1'b1; step(); lamp_out = 1'b0;
    count_mode(3'd4, 1'b0, n);
    chk(mode == 3'd1, "R8 back to heat", int'(mode), 1);
    repeat (20) step();
    lamp_out = 1'b1; step(); lamp_out = 1'b0;
    chk(mode == 3'd4, "R6 inhibit from heat", int'(mode), 4);
    count_mode(3'd4, 1'b0, n);
    chk(n == (21 / CHG) * DIS + 1, "R7 short inhibit", n, (21 / CHG) * DIS + 1);
    count_mode(3'd1, 1'b0, n);
    chk(n == restart_len, "R8 heat after heat interrupt", n, restart_len);

    for (int i = 0; i < 150; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 6) begin
        repeat (1 + ($urandom % 300)) step();
      end else if (r < 8) begin
        lamp_out = 1'b1; step(); lamp_out = 1'b0; step();
      end else if (r == 8) begin
        pwr_good = 1'b0;
        repeat (1 + ($urandom % 3)) step();
        pwr_good = 1'b1; step();
      end else begin
        lamp_out = 1'b1;
        repeat (1 + ($urandom % 5)) step();
        lamp_out = 1'b0; step();
      end
    end
    summary();
  end
endmodule